// File: doc/BRIEF.md
# Phase-Adjustable Pulse-Per-Second Divider

This block derives a once-per-second, active-low output pulse from a one-cycle 1 MHz count enable, with its phase set relative to the tick of a free-running master divider. The offset is a BCD number of microseconds, one BCD digit per decade, from 1 us up to a full second.

Inside, a chain of presettable decade counters is cleared and loaded at every master tick with the nines complement of the delay digits. A detector looks at the chain and reports the enable that makes every decade read nine. That enable starts the output pulse. When every digit is nine the complement is zero, so the chain simply tracks the master divider. In that case the detect is not sent to the output. It arms a coincidence path instead, and the pulse leaves on an enable only once a master tick has also been seen.

Everything is synchronous to one system clock with a synchronous active-high reset. The 1 MHz rate, the master tick and the delay digits all arrive as signals in that clock domain.

Top module: `pps_phase_divider`

## Requirements
- R1: During reset, and after reset until the first master tick, `pps_n` stays high and no pulse is produced.
- R2: Let the clamped delay value N be from 1 to 10^NDIG-2. At a master tick the chain is loaded with the nines complement of the digits. `pps_n` falls at the clock edge that samples the N-th counted `us_en` after that tick.
- R3: Once low, `pps_n` changes only at an edge where `us_en` is high. It returns high at the next `us_en` edge, so the pulse is exactly one enable period wide.
- R4: A `us_en` in the same cycle as `master_tick` is not counted.
- R5: If master ticks stop, the chain keeps counting and wraps, so the pulse repeats every 10^NDIG counted enables.
- R6: With every digit nine, no preset is applied (the chain starts at zero). The all-nines detect never drives `pps_n` directly.
- R7: In the all-nines setting, the detect stays armed through the next `us_en` and lapses at the second one. A master tick seen while it is armed sets a second condition. `pps_n` falls on the first `us_en` edge at which both conditions are already registered. If no tick arrives in time, no pulse is produced.
- R8: Digit i sits at `delay_bcd[4i+3:4i]`, with digit 0 being single microseconds. Any digit code above 9 is treated as 9.
- R9: `delay_bcd` is sampled only in the master-tick cycle. A change during a second takes effect from the next tick.
- R10: A setting of all zeros loads all nines. The pulse then falls on the 10^NDIG-th counted enable after the tick, which is one full second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| us_en | input | 1 | One-cycle 1 MHz count enable |
| master_tick | input | 1 | One-cycle tick from the master divider; triggers preset |
| delay_bcd | input | 4*NDIG | Delay in microseconds, one BCD digit per nibble |
| pps_n | output | 1 | Phase-shifted pulse, active low, one enable period wide |

## Verification
The hardest case to reach is the all-nines setting. There, the output depends on the master tick landing before, on, or after the enable that completes the second, and on the armed detect lapsing. The stimulus runs the bench master divider with three different tick lags relative to the completing enable, zero lag included so that the tick blocks an enable. It also stops the ticks while in the all-nines setting, so the armed detect must lapse and produce no pulse. A reduced digit count keeps a second short enough to cover many seconds, a wrap without ticks, and delay changes made in the middle of a second.

// File: rtl/ppsd_pkg.sv
package ppsd_pkg;

    typedef logic [3:0] bcd_t;

    localparam bcd_t BCD_NINE  = 4'd9;
    localparam bcd_t BCD_EIGHT = 4'd8;

    // State of the all-nines coincidence path
    typedef struct packed {
        logic arm_det;   // all-nines detect, stretched
        logic age;       // one enable has passed since arm_det was set
        logic arm_tick;  // master tick seen while armed
    } coin_state_t;

    function automatic bcd_t clamp_digit(bcd_t d);
        return (d > BCD_NINE) ? BCD_NINE : d;
    endfunction

    function automatic bcd_t nines_comp(bcd_t d);
        return BCD_NINE - clamp_digit(d);
    endfunction

endpackage

// File: rtl/ppsd_decade.sv
module ppsd_decade
    import ppsd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  bcd_t load_val,
    input  logic step,
    output bcd_t digit
);

    always_ff @(posedge clk) begin
        if (rst) begin
            digit <= '0;
        end else if (load) begin
            digit <= load_val;
        end else if (step) begin
            digit <= (digit == BCD_NINE) ? bcd_t'(0) : bcd_t'(digit + 4'd1);
        end
    end

endmodule

// File: rtl/ppsd_nines_detect.sv
module ppsd_nines_detect
    import ppsd_pkg::*;
#(
    parameter int NDIG = 6
) (
    input  logic [4*NDIG-1:0] chain,
    output logic [NDIG-1:0]   carry_ok,
    output logic              pre_nine
);

    logic [NDIG-1:0] pat;

    // carry_ok[i]: every decade below i reads nine
    assign carry_ok[0] = 1'b1;

    genvar gi;
    generate
        for (gi = 0; gi < NDIG; gi++) begin : g_pat
            if (gi == 0) begin : g_lsd
                assign pat[gi] = (chain[4*gi +: 4] == BCD_EIGHT);
            end else begin : g_upper
                assign pat[gi]      = (chain[4*gi +: 4] == BCD_NINE);
                assign carry_ok[gi] = carry_ok[gi-1] & (chain[4*(gi-1) +: 4] == BCD_NINE);
            end
        end
    endgenerate

    // one more step makes the whole chain read all nines
    assign pre_nine = &pat;

endmodule

// File: rtl/ppsd_coincide.sv
module ppsd_coincide
    import ppsd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic us_en,
    input  logic tick,
    input  logic det_zero,
    output logic fire,
    output logic arm_tick
);

    coin_state_t st, st_nx;

    assign fire     = us_en & st.arm_det & st.arm_tick;
    assign arm_tick = st.arm_tick;

    always_comb begin
        st_nx = st;
        if (fire) begin
            st_nx.arm_tick = 1'b0;
        end else if (tick && st.arm_det) begin
            st_nx.arm_tick = 1'b1;
        end
        if (det_zero) begin
            st_nx.arm_det = 1'b1;
            st_nx.age     = 1'b0;
        end else if (fire) begin
            st_nx.arm_det = 1'b0;
            st_nx.age     = 1'b0;
        end else if (us_en && st.arm_det) begin
            if (st.age) begin
                st_nx.arm_det = 1'b0;
                st_nx.age     = 1'b0;
            end else begin
                st_nx.age = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st <= st_nx;
        end
    end

endmodule

// File: rtl/pps_phase_divider.sv
module pps_phase_divider
    import ppsd_pkg::*;
#(
    parameter int NDIG = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              us_en,
    input  logic              master_tick,
    input  logic [4*NDIG-1:0] delay_bcd,
    output logic              pps_n
);

    localparam int W = 4 * NDIG;

    logic [W-1:0]    preset_vec;
    logic [W-1:0]    chain;
    logic [NDIG-1:0] zero_dig;
    logic [NDIG-1:0] carry_ok;
    logic            loaded;
    logic            zero_mode;
    logic            count_en;
    logic            pre_nine;
    logic            det_hit;
    logic            norm_fire;
    logic            det_zero;
    logic            zero_fire;
    logic            z_arm_tick;

    // counting is held off until the first preset and during the preset cycle
    assign count_en = us_en & loaded & ~master_tick;

    genvar gi;
    generate
        for (gi = 0; gi < NDIG; gi++) begin : g_dec
            assign preset_vec[4*gi +: 4] = nines_comp(delay_bcd[4*gi +: 4]);
            assign zero_dig[gi]          = (preset_vec[4*gi +: 4] == 4'd0);

            ppsd_decade u_dec (
                .clk      (clk),
                .rst      (rst),
                .load     (master_tick),
                .load_val (preset_vec[4*gi +: 4]),
                .step     (count_en & carry_ok[gi]),
                .digit    (chain[4*gi +: 4])
            );
        end
    endgenerate

    ppsd_nines_detect #(.NDIG(NDIG)) u_det (
        .chain    (chain),
        .carry_ok (carry_ok),
        .pre_nine (pre_nine)
    );

    assign det_hit   = count_en & pre_nine;
    assign norm_fire = det_hit & ~zero_mode;
    assign det_zero  = det_hit & zero_mode;

    ppsd_coincide u_coin (
        .clk      (clk),
        .rst      (rst),
        .us_en    (us_en),
        .tick     (master_tick),
        .det_zero (det_zero),
        .fire     (zero_fire),
        .arm_tick (z_arm_tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            loaded    <= 1'b0;
            zero_mode <= 1'b0;
        end else if (master_tick) begin
            loaded    <= 1'b1;
            zero_mode <= &zero_dig;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pps_n <= 1'b1;
        end else if (us_en) begin
            pps_n <= ~(norm_fire | zero_fire);
        end
    end

endmodule

// File: rtl/ppsd_checker.sv
module ppsd_checker #(
    parameter int NDIG = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              us_en,
    input logic              master_tick,
    input logic              pps_n,
    input logic              zero_mode,
    input logic              z_arm_tick,
    input logic [4*NDIG-1:0] chain,
    input logic [4*NDIG-1:0] preset_vec
);

    logic seen_tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_tick <= 1'b0;
        end else if (master_tick) begin
            seen_tick <= 1'b1;
        end
    end

    p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
        !seen_tick |-> pps_n);

    p_preset_load_r2: assert property (@(posedge clk) disable iff (rst)
        master_tick |=> (chain == $past(preset_vec)));

    p_fall_on_enable_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(pps_n) |-> $past(us_en));

    p_hold_between_en_r3: assert property (@(posedge clk) disable iff (rst)
        !us_en |=> $stable(pps_n));

    p_zero_no_direct_r6: assert property (@(posedge clk) disable iff (rst)
        (zero_mode && us_en && !z_arm_tick) |=> pps_n);

    p_arm_needs_tick_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(z_arm_tick) |-> $past(master_tick));

endmodule

bind pps_phase_divider ppsd_checker #(.NDIG(NDIG)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .us_en       (us_en),
    .master_tick (master_tick),
    .pps_n       (pps_n),
    .zero_mode   (zero_mode),
    .z_arm_tick  (z_arm_tick),
    .chain       (chain),
    .preset_vec  (preset_vec)
);

// File: tb/sim_pps_phase_divider.sv
module sim_pps_phase_divider;

    localparam int NDIG = 3;
    localparam int W    = 4 * NDIG;
    localparam int M    = 1000;   // 10**NDIG
    localparam int PER  = 3;      // clocks per enable

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         us_en = 1'b0;
    logic         master_tick = 1'b0;
    logic [W-1:0] delay_bcd = '0;
    logic         pps_n;

    int    total = 0;
    int    bad = 0;
    string cur_req = "R1";
    int    cyc = 0;

    // driver controls
    int tick_on = 0;
    int lag = 1;
    int ens = M - 3;
    int tick_wait = 0;
    int phase_ctr = 0;
    int tick_total = 0;
    int falls = 0;
    bit prev_pps = 1'b1;

    // reference model state
    int m_cnt = 0;
    int m_n = 0;
    bit m_loaded = 0;
    bit m_zero = 0;
    bit m_arm = 0;
    bit m_age = 0;
    bit m_armt = 0;
    bit exp_n = 1'b1;

    always #5 clk = ~clk;

    pps_phase_divider #(.NDIG(NDIG)) u0 (
        .clk         (clk),
        .rst         (rst),
        .us_en       (us_en),
        .master_tick (master_tick),
        .delay_bcd   (delay_bcd),
        .pps_n       (pps_n)
    );

    function automatic int dval(logic [W-1:0] d);
        int v = 0;
        for (int i = NDIG - 1; i >= 0; i--) begin
            int g;
            g = int'(d[4*i +: 4]);
            if (g > 9) g = 9;
            v = v * 10 + g;
        end
        return v;
    endfunction

    // behavioural reference, from the requirements
    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_n = 0; m_loaded = 0; m_zero = 0;
            m_arm = 0; m_age = 0; m_armt = 0; exp_n = 1'b1;
        end else begin
            bit fz, hit, fn, dz, nt;
            fz  = us_en && m_arm && m_armt;
            hit = us_en && m_loaded && !master_tick && (((m_cnt + 1) % M) == m_n);
            fn  = hit && !m_zero;
            dz  = hit && m_zero;
            if (us_en) exp_n = !(fn || fz);
            nt = fz ? 1'b0 : ((master_tick && m_arm) ? 1'b1 : m_armt);
            if (dz) begin m_arm = 1; m_age = 0; end
            else if (fz) begin m_arm = 0; m_age = 0; end
            else if (us_en && m_arm) begin
                if (m_age) begin m_arm = 0; m_age = 0; end
                else m_age = 1;
            end
            m_armt = nt;
            if (us_en && m_loaded && !master_tick) m_cnt = (m_cnt + 1) % M;
            if (master_tick) begin
                m_loaded = 1;
                m_cnt    = 0;
                m_n      = dval(delay_bcd);
                m_zero   = (m_n == M - 1);
            end
        end
    end

    // compare, then drive the enable and the master divider
    always @(negedge clk) begin
        cyc++;
        total++;
        if (pps_n !== exp_n) begin
            bad++;
            $display("FAIL %s: pps_n=%b expected=%b cycle=%0d", cur_req, pps_n, exp_n, cyc);
        end
        if (prev_pps && !pps_n) falls++;
        prev_pps = pps_n;

        master_tick = 1'b0;
        us_en = (phase_ctr == 0);
        phase_ctr = (phase_ctr + 1) % PER;
        if (tick_wait > 0) begin
            tick_wait--;
            if (tick_wait == 0 && tick_on != 0) begin master_tick = 1'b1; tick_total++; end
        end
        if (us_en && !rst) begin
            ens++;
            if (ens >= M) begin
                ens = 0;
                if (lag == 0) begin
                    if (tick_on != 0) begin master_tick = 1'b1; tick_total++; end
                end else begin
                    tick_wait = lag;
                end
            end
        end
    end

    task automatic wait_ticks(int n);
        int target;
        target = tick_total + n;
        while (tick_total < target) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_falls(string req, int expv);
        total++;
        if (falls != expv) begin
            bad++;
            $display("FAIL %s: pulses=%0d expected=%0d", req, falls, expv);
        end
    endtask

    task automatic steady(string req, logic [W-1:0] d, int lg, int secs);
        cur_req = req;
        delay_bcd = d;
        lag = lg;
        wait_ticks(2);
        falls = 0;
        wait_ticks(secs);
        check_falls(req, secs);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset, then enables without any master tick
        cur_req = "R1";
        delay_bcd = 12'h001;
        repeat (6) @(negedge clk);
        rst = 1'b0;
        falls = 0;
        repeat (60) @(negedge clk);
        check_falls("R1", 0);
        tick_on = 1;

        // R2: one microsecond delay
        steady("R2", 12'h001, 1, 2);
        // R3: two microseconds, later tick lag
        steady("R3", 12'h002, 2, 2);
        // R4: tick coincides with an enable
        steady("R4", 12'h137, 0, 2);
        // R8: out-of-range digits clamp to 9 (value 909)
        steady("R8", 12'hF0A, 1, 2);

        // R9: change delay mid-second
        cur_req = "R9";
        delay_bcd = 12'h500;
        lag = 1;
        wait_ticks(2);
        repeat (100) @(negedge clk);
        delay_bcd = 12'h010;
        wait_ticks(2);

        // R10: all zeros gives a full second
        steady("R10", 12'h000, 1, 2);

        // R5: ticks stop, chain wraps
        cur_req = "R5";
        delay_bcd = 12'h003;
        wait_ticks(2);
        repeat (20) @(negedge clk);
        tick_on = 0;
        falls = 0;
        repeat (2 * M * PER) @(negedge clk);
        check_falls("R5", 2);
        tick_on = 1;

        // R6, R7: all-nines setting under three tick lags
        cur_req = "R6";
        delay_bcd = 12'h999;
        lag = 1;
        wait_ticks(3);
        cur_req = "R7";
        falls = 0;
        wait_ticks(2);
        check_falls("R7", 2);
        lag = 0;
        wait_ticks(2);
        lag = 2;
        wait_ticks(2);

        // R7: no tick, armed detect lapses
        repeat (20) @(negedge clk);
        tick_on = 0;
        falls = 0;
        repeat (2 * M * PER) @(negedge clk);
        check_falls("R7", 0);
        tick_on = 1;

        // R6: leave all-nines setting
        steady("R6", 12'h004, 1, 2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule